// File: doc/BRIEF.md
# Four-Input Edge/Level External Interrupt Controller

This block watches four external interrupt pins and turns activity on them into per-pin interrupt requests. Each pin has its own two-bit sense field that selects one of four triggers: held low, any change, falling edge or rising edge. Pins are sampled whatever their direction, so firmware that drives one of these pins can raise an interrupt in software.

A small register port gives access to three registers. The sense register holds the four fields. The mask register holds one enable bit per pin. The flag register holds one sticky event bit per pin. Software clears a flag bit by writing a one to it, and hardware clears it when the CPU acknowledges that pin's vector. Edge triggers set the sticky flag. The low-level trigger does not set it: its request follows the synchronised pin directly, and only while the pin stays low. A pin's request reaches the CPU only when its mask bit and the global interrupt-enable input are both set.

Top module: `extint_ctrl`

## Requirements
- R1: After reset the sense, mask and flag registers all read 0 and `irqReq` is 0.
- R2: Registers are selected by `addr`: 0 is the sense register, 1 is the mask register and 2 is the flag register. The sense field of pin n sits in bits 2n+1:2n. The mask and flag registers use bits 3:0, and their bits 7:4 read as 0.
- R3: Sense code 00 selects low level. With the mask bit and the global enable set, the request is high while the synchronised pin is low. It rises on the second rising clock edge after the pin falls and drops on the second edge after the pin rises. No flag is set.
- R4: Sense code 01 sets the pin's flag on every change of the synchronised pin, in either direction.
- R5: Sense code 10 sets the flag on a falling edge only. A rising edge leaves the flag clear.
- R6: Sense code 11 sets the flag on a rising edge only. A falling edge leaves the flag clear.
- R7: In the edge modes, `irqReq[n]` equals the flag of pin n ANDed with mask bit n and with `globalEn`.
- R8: A write to the flag register clears each flag whose data bit is 1. A bit written as 0 leaves its flag unchanged.
- R9: A cycle with `ackValid` high clears only the flag selected by `ackIdx`. An edge detected in the same cycle keeps its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 4 | Asynchronous interrupt pins |
| globalEn | input | 1 | Global interrupt enable |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data, combinational from `addr` |
| ackValid | input | 1 | Vector acknowledge strobe |
| ackIdx | input | 2 | Index of the acknowledged pin |
| irqReq | output | 4 | Per-pin interrupt requests |

## Verification
Each edge mode is driven with both a falling and a rising transition. This shows which direction a mode accepts and which it ignores, and it separates the any-change code from the two single-direction codes. The low-level mode is checked one cycle before and one cycle after the expected request change, which pins down the synchroniser latency and confirms that no flag is set. Several flags are set together before software clears and acknowledge strobes are applied, so that a clear which reaches the wrong bit, or which ignores a zero data bit, changes the flag readback.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int unsigned PIN_CNT = 4;
  localparam int unsigned SENSE_W = 2;
  localparam int unsigned REG_W   = PIN_CNT * SENSE_W;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned IDX_W   = $clog2(PIN_CNT);

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_SENSE = 2'd0,
    ADDR_MASK  = 2'd1,
    ADDR_FLAG  = 2'd2,
    ADDR_NONE  = 2'd3
  } addr_e;

  typedef struct packed {
    logic               wrSense;
    logic               wrMask;
    logic [PIN_CNT-1:0] clrFlag;
  } strobe_t;
endpackage

// File: rtl/extint_control.sv
module extint_control
  import extint_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              ackValid,
  input  logic [IDX_W-1:0]  ackIdx,
  output strobe_t           strobe
);
  // Software clears and the hardware acknowledge share one clear vector.
  always_comb begin
    strobe = '0;
    if (wrEn) begin
      case (addr_e'(addr))
        ADDR_SENSE: strobe.wrSense = 1'b1;
        ADDR_MASK:  strobe.wrMask  = 1'b1;
        ADDR_FLAG:  strobe.clrFlag = wrData[PIN_CNT-1:0];
        default:    ;
      endcase
    end
    if (ackValid) strobe.clrFlag[ackIdx] = 1'b1;
  end
endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PIN_CNT-1:0] pinIn,
  input  logic               globalEn,
  input  strobe_t            strobe,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   senseQ,
  output logic [PIN_CNT-1:0] maskQ,
  output logic [PIN_CNT-1:0] flagQ,
  output logic [PIN_CNT-1:0] edgeEvt,
  output logic [PIN_CNT-1:0] irqReq
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      senseQ <= '0;
      maskQ  <= '0;
    end else begin
      if (strobe.wrSense) senseQ <= wrData;
      if (strobe.wrMask)  maskQ  <= wrData[PIN_CNT-1:0];
    end
  end

  for (genvar g = 0; g < PIN_CNT; g++) begin : gPin
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   prevQ;
    logic                   cur;
    logic                   rise;
    logic                   fall;
    logic                   pending;
    sense_e                 mode;

    // Pins idle high, so the chain resets to 1 and no edge appears after reset.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncQ <= '1;
        prevQ <= 1'b1;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn[g]};
        prevQ <= syncQ[SYNC_STAGES-1];
      end
    end

    assign cur  = syncQ[SYNC_STAGES-1];
    assign rise = cur & ~prevQ;
    assign fall = ~cur & prevQ;
    assign mode = sense_e'(senseQ[g*SENSE_W +: SENSE_W]);

    always_comb begin
      case (mode)
        SENSE_ANY:  edgeEvt[g] = rise | fall;
        SENSE_FALL: edgeEvt[g] = fall;
        SENSE_RISE: edgeEvt[g] = rise;
        default:    edgeEvt[g] = 1'b0;
      endcase
    end

    // A new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
      if (!rstN)                  flagQ[g] <= 1'b0;
      else if (edgeEvt[g])        flagQ[g] <= 1'b1;
      else if (strobe.clrFlag[g]) flagQ[g] <= 1'b0;
    end

    assign pending   = (mode == SENSE_LOW) ? ~cur : flagQ[g];
    assign irqReq[g] = pending & maskQ[g] & globalEn;
  end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PIN_CNT-1:0] pinIn,
  input  logic               globalEn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic               ackValid,
  input  logic [IDX_W-1:0]   ackIdx,
  output logic [PIN_CNT-1:0] irqReq
);
  strobe_t            strobe;
  logic [REG_W-1:0]   senseQ;
  logic [PIN_CNT-1:0] maskQ;
  logic [PIN_CNT-1:0] flagQ;
  logic [PIN_CNT-1:0] edgeEvt;

  extint_control uCtl (
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .ackValid(ackValid),
    .ackIdx  (ackIdx),
    .strobe  (strobe)
  );

  extint_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .globalEn(globalEn),
    .strobe  (strobe),
    .wrData  (wrData),
    .senseQ  (senseQ),
    .maskQ   (maskQ),
    .flagQ   (flagQ),
    .edgeEvt (edgeEvt),
    .irqReq  (irqReq)
  );

  always_comb begin
    case (addr_e'(addr))
      ADDR_SENSE: rdData = senseQ;
      ADDR_MASK:  rdData = REG_W'(maskQ);
      ADDR_FLAG:  rdData = REG_W'(flagQ);
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk
  import extint_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               globalEn,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [REG_W-1:0]   wrData,
  input logic               ackValid,
  input logic [IDX_W-1:0]   ackIdx,
  input logic [REG_W-1:0]   senseQ,
  input logic [PIN_CNT-1:0] maskQ,
  input logic [PIN_CNT-1:0] flagQ,
  input logic [PIN_CNT-1:0] edgeEvt,
  input logic [PIN_CNT-1:0] irqReq
);
  for (genvar g = 0; g < PIN_CNT; g++) begin : gChk
    a_r7_req_gated: assert property (@(posedge clk) disable iff (!rstN)
      irqReq[g] |-> (globalEn && maskQ[g]));

    a_r3_level_no_flag: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagQ[g]) |-> ($past(senseQ[g*SENSE_W +: SENSE_W]) != 2'b00));

    a_r4_edge_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
      edgeEvt[g] |=> flagQ[g]);

    a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == ADDR_W'(2) && wrData[g] && !edgeEvt[g]) |=> !flagQ[g]);

    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
      (ackValid && ackIdx == IDX_W'(g) && !edgeEvt[g]) |=> !flagQ[g]);
  end
endmodule

bind extint_ctrl extint_ctrl_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .globalEn(globalEn),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrData  (wrData),
  .ackValid(ackValid),
  .ackIdx  (ackIdx),
  .senseQ  (senseQ),
  .maskQ   (maskQ),
  .flagQ   (flagQ),
  .edgeEvt (edgeEvt),
  .irqReq  (irqReq)
);

// File: tb/tb_extint_ctrl.sv
module tb_extint_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] pinIn = 4'hF;
  logic       globalEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       ackValid = 1'b0;
  logic [1:0] ackIdx = 2'd0;
  logic [3:0] irqReq;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  extint_ctrl dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .globalEn(globalEn),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .ackValid(ackValid), .ackIdx(ackIdx), .irqReq(irqReq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic setPin(input int idx, input logic v);
    @(negedge clk);
    pinIn[idx] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic ack(input logic [1:0] idx);
    @(negedge clk);
    ackValid = 1'b1; ackIdx = idx;
    @(negedge clk);
    ackValid = 1'b0;
  endtask

  task automatic tReset();
    logic [7:0] d;
    regRead(2'd0, d); check("R1 sense", d, 8'h00);
    regRead(2'd1, d); check("R1 mask", d, 8'h00);
    regRead(2'd2, d); check("R1 flag", d, 8'h00);
    check("R1 irqReq", {4'h0, irqReq}, 8'h00);
  endtask

  task automatic tRegs();
    logic [7:0] d;
    regWrite(2'd0, 8'hE4); regRead(2'd0, d); check("R2 sense", d, 8'hE4);
    regWrite(2'd1, 8'hFF); regRead(2'd1, d); check("R2 mask", d, 8'h0F);
    regRead(2'd3, d); check("R2 unused", d, 8'h00);
    regWrite(2'd1, 8'h00);
  endtask

  task automatic tLevel();
    logic [7:0] d;
    regWrite(2'd0, 8'h00);
    regWrite(2'd1, 8'h01);
    globalEn = 1'b1;
    @(negedge clk); pinIn[0] = 1'b0;
    @(negedge clk); check("R3 one edge", {4'h0, irqReq}, 8'h00);
    @(negedge clk); check("R3 two edges", {4'h0, irqReq}, 8'h01);
    regRead(2'd2, d); check("R3 no flag", d, 8'h00);
    @(negedge clk); pinIn[0] = 1'b1;
    repeat (2) @(negedge clk); check("R3 release", {4'h0, irqReq}, 8'h00);
    globalEn = 1'b0;
    regWrite(2'd1, 8'h00);
  endtask

  task automatic tEdges();
    logic [7:0] d;
    regWrite(2'd0, 8'hE4); // pin1 any, pin2 falling, pin3 rising
    regWrite(2'd2, 8'h0F);
    setPin(1, 1'b0); regRead(2'd2, d); check("R4 fall", d, 8'h02);
    regWrite(2'd2, 8'h02);
    setPin(1, 1'b1); regRead(2'd2, d); check("R4 rise", d, 8'h02);
    regWrite(2'd2, 8'h0F);
    setPin(2, 1'b0); regRead(2'd2, d); check("R5 fall", d, 8'h04);
    regWrite(2'd2, 8'h0F);
    setPin(2, 1'b1); regRead(2'd2, d); check("R5 rise ignored", d, 8'h00);
    setPin(3, 1'b0); regRead(2'd2, d); check("R6 fall ignored", d, 8'h00);
    setPin(3, 1'b1); regRead(2'd2, d); check("R6 rise", d, 8'h08);
  endtask

  task automatic tGate();
    globalEn = 1'b1;
    repeat (2) @(negedge clk); check("R7 mask off", {4'h0, irqReq}, 8'h00);
    globalEn = 1'b0;
    regWrite(2'd1, 8'h08);
    @(negedge clk); check("R7 gie off", {4'h0, irqReq}, 8'h00);
    globalEn = 1'b1;
    #1 check("R7 both on", {4'h0, irqReq}, 8'h08);
  endtask

  task automatic tClear();
    logic [7:0] d;
    setPin(1, 1'b0); regRead(2'd2, d); check("R8 setup", d, 8'h0A);
    regWrite(2'd2, 8'h00); regRead(2'd2, d); check("R8 zero write", d, 8'h0A);
    regWrite(2'd2, 8'h02); regRead(2'd2, d); check("R8 clear one", d, 8'h08);
    check("R7 req follows flag", {4'h0, irqReq}, 8'h08);
  endtask

  task automatic tAck();
    logic [7:0] d;
    setPin(1, 1'b1); regRead(2'd2, d); check("R9 setup", d, 8'h0A);
    ack(2'd3); regRead(2'd2, d); check("R9 ack pin3", d, 8'h02);
    check("R9 req dropped", {4'h0, irqReq}, 8'h00);
    ack(2'd0); regRead(2'd2, d); check("R9 ack other", d, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tRegs();
    tLevel();
    tEdges();
    tGate();
    tClear();
    tAck();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule